// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock for the controller side of an I2C bus. The clock is open-drain. The block pulls the line low for a programmed number of cycles, then releases it. It counts the high time only once the line is actually seen high. At the end of the high time it pulls the line low again. Two pairs of count inputs, one for standard speed and one for fast speed, set the low and high times. A mode input picks which pair is used.

The SCL and SDA pins are noisy and asynchronous, so each one passes through a two-flop synchronizer and then a 2-of-3 majority vote. The cleaned lines are also provided as outputs for the rest of the controller.

Several masters can share the bus. The block watches the cleaned SCL line for this purpose. A device that keeps the line low after the block has released it delays the start of the high count. A device that pulls the line low during the high time ends that high time at once and starts a new low count. One-cycle strobes mark the start of every low phase and every high phase, so that shift logic elsewhere knows when to change or sample SDA.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, `scl_drive_low` is 0, `scl_filt` and `sda_filt` are 1, and both strobes are 0.
- R2: When `fast_mode` is 0, the standard-speed pair (`std_hcnt`, `std_lcnt`) sets the timing. When `fast_mode` is 1, the fast-speed pair (`fast_hcnt`, `fast_lcnt`) sets it.
- R3: A low count below 8 is used as 8. A high count below 6 is used as 6.
- R4: Each driven-low period lasts the low count plus 1 clock cycles, counted as cycles with `scl_drive_low` = 1.
- R5: When no other device holds SCL, the pin stays high for the high count plus 7 cycles. This is 4 cycles of filter delay plus 3 cycles of drive latency.
- R6: A level change on a pin input shows on its filtered output at the fourth rising edge, where the first rising edge that sees the new level counts as the first. A pulse only one cycle wide never reaches the filtered output.
- R7: After a release, the high count starts only once filtered SCL is high. If the pin is released by an outside device, `scl_drive_low` rises on the rising edge that is high count plus 6 edges after the first edge that sees the pin high.
- R8: If another device pulls SCL low during the high count, the block asserts `scl_drive_low` on the fifth rising edge after the pin falls. It then holds it for a full low count plus 1 cycles.
- R9: While `en` is 0, `scl_drive_low` is 0 from the next cycle on and no strobes are issued. When `en` is set again, the block begins with a high phase. `high_strobe` is then seen 2 cycles after `en` is raised, on a line that is already high.
- R10: `low_strobe` is 1 for exactly the first cycle of each driven-low period. `high_strobe` is 1 for one cycle, 5 cycles after the block's own release, when the high count begins. The two strobes are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables clock generation |
| fast_mode | input | 1 | 1 selects the fast-speed count pair |
| std_hcnt | input | CNT_W | Standard-speed high count |
| std_lcnt | input | CNT_W | Standard-speed low count |
| fast_hcnt | input | CNT_W | Fast-speed high count |
| fast_lcnt | input | CNT_W | Fast-speed low count |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| scl_drive_low | output | 1 | 1 pulls SCL low (open drain) |
| scl_filt | output | 1 | Filtered SCL |
| sda_filt | output | 1 | Filtered SDA |
| low_strobe | output | 1 | Marks the first cycle of a driven-low period |
| high_strobe | output | 1 | Marks the start of the high count |

## Verification
A wrong phase or counter value shows up on `scl_drive_low` within a single low or high period. That period is then too long or too short by a known number of cycles, or the drive edge moves relative to a pin change made by the bench. Faults in the filter pipeline move the filtered edge away from the fourth rising edge, or let a one-cycle pulse through, within a few cycles. A wrong state after `en` falls, or after an outside pull, shows up at once: either a strobe appears or the drive stays asserted on the next cycle.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_t;
endpackage

// File: rtl/scl_line_filter.sv
module scl_line_filter #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [1:0]             hist_q;
  logic                   newest;
  logic                   vote;

  assign newest = sync_q[SYNC_STAGES-1];
  assign vote   = (newest & hist_q[0]) | (newest & hist_q[1]) | (hist_q[0] & hist_q[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '1;
      hist_q <= '1;
      filt   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[0], newest};
      filt   <= vote;
    end
  end

  // R6: a filtered change needs two agreeing history samples
  a_r6_needs_agreement: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> ($past(newest) == filt || $past(hist_q[0]) == filt) && $past(hist_q[1]) == filt
      || ($past(newest) == filt && $past(hist_q[0]) == filt));
endmodule

// File: rtl/scl_count_select.sv
module scl_count_select #(
  parameter int CNT_W    = 16,
  parameter int LOW_MIN  = 8,
  parameter int HIGH_MIN = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fast_mode,
  input  logic [CNT_W-1:0] std_h,
  input  logic [CNT_W-1:0] std_l,
  input  logic [CNT_W-1:0] fast_h,
  input  logic [CNT_W-1:0] fast_l,
  output logic [CNT_W-1:0] eff_h,
  output logic [CNT_W-1:0] eff_l
);
  localparam logic [CNT_W-1:0] LMIN = CNT_W'(LOW_MIN);
  localparam logic [CNT_W-1:0] HMIN = CNT_W'(HIGH_MIN);

  logic [CNT_W-1:0] pick_h, pick_l;

  always_comb begin
    pick_h = fast_mode ? fast_h : std_h;
    pick_l = fast_mode ? fast_l : std_l;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_h <= HMIN;
      eff_l <= LMIN;
    end else begin
      eff_h <= (pick_h < HMIN) ? HMIN : pick_h;
      eff_l <= (pick_l < LMIN) ? LMIN : pick_l;
    end
  end

  a_r3_floor_kept: assert property (@(posedge clk) disable iff (rst)
    eff_l >= LMIN && eff_h >= HMIN);
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_gen_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int DRIVE_LAT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             line_hi,
  input  logic [CNT_W-1:0] eff_h,
  input  logic [CNT_W-1:0] eff_l,
  output logic             drive_low,
  output logic             low_stb,
  output logic             high_stb
);
  localparam int CW = CNT_W + 2;

  phase_t          phase;
  logic [CW-1:0]   cnt;
  logic [CW-1:0]   high_end;
  logic [CW-1:0]   low_end;

  assign high_end = CW'(eff_h) + CW'(DRIVE_LAT) - CW'(1);
  assign low_end  = CW'(eff_l);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      drive_low <= 1'b0;
      low_stb   <= 1'b0;
      high_stb  <= 1'b0;
    end else begin
      low_stb  <= 1'b0;
      high_stb <= 1'b0;
      if (!en) begin
        phase     <= PH_IDLE;
        cnt       <= '0;
        drive_low <= 1'b0;
      end else begin
        case (phase)
          PH_IDLE: phase <= PH_WAIT;
          PH_WAIT: begin
            if (line_hi) begin
              phase    <= PH_HIGH;
              cnt      <= CW'(1);
              high_stb <= 1'b1;
            end
          end
          PH_HIGH: begin
            if (!line_hi || cnt >= high_end) begin
              phase     <= PH_LOW;
              cnt       <= '0;
              drive_low <= 1'b1;
              low_stb   <= 1'b1;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          PH_LOW: begin
            if (cnt >= low_end) begin
              phase     <= PH_WAIT;
              cnt       <= '0;
              drive_low <= 1'b0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  a_r9_off_releases: assert property (@(posedge clk) disable iff (rst)
    !en |=> !drive_low && !low_stb && !high_stb);
  a_r10_strobes_apart: assert property (@(posedge clk) disable iff (rst)
    !(low_stb && high_stb));
  a_r10_low_strobe_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low) |-> low_stb);
  a_r7_wait_released: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_WAIT) |-> !drive_low);
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int LOW_MIN     = 8,
  parameter int HIGH_MIN    = 6,
  parameter int DRIVE_LAT   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fast_mode,
  input  logic [CNT_W-1:0] std_hcnt,
  input  logic [CNT_W-1:0] std_lcnt,
  input  logic [CNT_W-1:0] fast_hcnt,
  input  logic [CNT_W-1:0] fast_lcnt,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             scl_filt,
  output logic             sda_filt,
  output logic             low_strobe,
  output logic             high_strobe
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] clean_lines;
  logic [CNT_W-1:0]  eff_h, eff_l;

  assign raw_lines = {sda_in, scl_in};

  for (genvar i = 0; i < NLINES; i++) begin : g_filt
    scl_line_filter #(.SYNC_STAGES(SYNC_STAGES)) u_filt (
      .clk (clk),
      .rst (rst),
      .raw (raw_lines[i]),
      .filt(clean_lines[i])
    );
  end

  assign scl_filt = clean_lines[0];
  assign sda_filt = clean_lines[1];

  scl_count_select #(.CNT_W(CNT_W), .LOW_MIN(LOW_MIN), .HIGH_MIN(HIGH_MIN)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .fast_mode(fast_mode),
    .std_h    (std_hcnt),
    .std_l    (std_lcnt),
    .fast_h   (fast_hcnt),
    .fast_l   (fast_lcnt),
    .eff_h    (eff_h),
    .eff_l    (eff_l)
  );

  scl_phase_ctrl #(.CNT_W(CNT_W), .DRIVE_LAT(DRIVE_LAT)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .line_hi  (clean_lines[0]),
    .eff_h    (eff_h),
    .eff_l    (eff_l),
    .drive_low(scl_drive_low),
    .low_stb  (low_strobe),
    .high_stb (high_strobe)
  );
endmodule

// File: tb/sim_scl_timing_gen.sv
module sim_scl_timing_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic fast_mode = 1'b0;
  logic [15:0] std_hcnt = 16'd10, std_lcnt = 16'd12, fast_hcnt = 16'd7, fast_lcnt = 16'd9;
  logic ext_hold = 1'b0;
  logic sda_in = 1'b1;
  logic scl_in;
  logic scl_drive_low, scl_filt, sda_filt, low_strobe, high_strobe;
  int total = 0, bad = 0;

  always #4 clk = ~clk;
  assign scl_in = ~scl_drive_low & ~ext_hold;

  scl_timing_gen u0 (
    .clk(clk), .rst(rst), .en(en), .fast_mode(fast_mode),
    .std_hcnt(std_hcnt), .std_lcnt(std_lcnt), .fast_hcnt(fast_hcnt), .fast_lcnt(fast_lcnt),
    .scl_in(scl_in), .sda_in(sda_in),
    .scl_drive_low(scl_drive_low), .scl_filt(scl_filt), .sda_filt(sda_filt),
    .low_strobe(low_strobe), .high_strobe(high_strobe)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_drive(input logic lvl);
    while (scl_drive_low !== lvl) @(negedge clk);
  endtask

  task automatic restart(input logic fm, input int h, input int l);
    en = 1'b0;
    fast_mode = fm;
    if (fm) begin fast_hcnt = 16'(h); fast_lcnt = 16'(l); end
    else begin std_hcnt = 16'(h); std_lcnt = 16'(l); end
    nclk(8);
    en = 1'b1;
  endtask

  task automatic measure(input string req, input int exp_lo, input int exp_hi);
    int lo = 0, hi = 0;
    wait_drive(1'b1);
    wait_drive(1'b0);
    wait_drive(1'b1);
    check("R10 low_strobe first cycle", int'(low_strobe), 1);
    while (scl_drive_low) begin lo++; @(negedge clk); end
    while (!scl_drive_low) begin hi++; @(negedge clk); end
    check({req, " low length"}, lo, exp_lo);
    check({req, " high length"}, hi, exp_hi);
  endtask

  task automatic t_reset;
    check("R1 drive", int'(scl_drive_low), 0);
    check("R1 scl_filt", int'(scl_filt), 1);
    check("R1 sda_filt", int'(sda_filt), 1);
    check("R1 strobes", int'(low_strobe | high_strobe), 0);
  endtask

  task automatic t_filter;
    sda_in = 1'b0;
    nclk(3);
    check("R6 not yet at 3", int'(sda_filt), 1);
    nclk(1);
    check("R6 seen at 4", int'(sda_filt), 0);
    sda_in = 1'b1;
    nclk(8);
    sda_in = 1'b0;
    nclk(1);
    sda_in = 1'b1;
    for (int i = 0; i < 8; i++) begin
      check("R6 glitch rejected", int'(sda_filt), 1);
      nclk(1);
    end
  endtask

  task automatic t_std;
    int n = 0;
    restart(1'b0, 10, 12);
    wait_drive(1'b1);
    nclk(1);
    check("R10 low_strobe one cycle", int'(low_strobe), 0);
    wait_drive(1'b0);
    while (!high_strobe) begin n++; @(negedge clk); end
    check("R10 high_strobe delay", n, 5);
    nclk(1);
    check("R10 high_strobe one cycle", int'(high_strobe), 0);
    measure("R4 R5 R2 std", 13, 17);
  endtask

  task automatic t_fast;
    restart(1'b1, 7, 9);
    measure("R2 fast", 10, 14);
  endtask

  task automatic t_clamp;
    restart(1'b0, 2, 3);
    measure("R3 clamp", 9, 13);
  endtask

  task automatic t_stretch;
    int n = 0;
    int seen = 0;
    restart(1'b0, 10, 12);
    wait_drive(1'b1);
    ext_hold = 1'b1;
    wait_drive(1'b0);
    for (int i = 0; i < 20; i++) begin
      seen = seen | int'(scl_drive_low) | int'(high_strobe);
      nclk(1);
    end
    check("R7 idle while held", seen, 0);
    ext_hold = 1'b0;
    do begin @(negedge clk); n++; end while (!scl_drive_low);
    check("R7 high after outside release", n, 17);
  endtask

  task automatic t_pull;
    int n = 0;
    int lo = 0;
    restart(1'b0, 10, 12);
    wait_drive(1'b1);
    wait_drive(1'b0);
    while (!high_strobe) @(negedge clk);
    nclk(1);
    ext_hold = 1'b1;
    do begin @(negedge clk); n++; end while (!scl_drive_low);
    check("R8 drive after pull", n, 5);
    ext_hold = 1'b0;
    while (scl_drive_low) begin lo++; @(negedge clk); end
    check("R8 restarted low length", lo, 13);
  endtask

  task automatic t_disable;
    int seen = 0;
    restart(1'b0, 10, 12);
    wait_drive(1'b1);
    en = 1'b0;
    nclk(1);
    check("R9 released next cycle", int'(scl_drive_low), 0);
    for (int i = 0; i < 10; i++) begin
      seen = seen | int'(scl_drive_low) | int'(low_strobe) | int'(high_strobe);
      nclk(1);
    end
    check("R9 quiet while off", seen, 0);
    en = 1'b1;
    nclk(2);
    check("R9 resumes with high phase", int'(high_strobe), 1);
    check("R9 not driving at resume", int'(scl_drive_low), 0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    nclk(3);
    rst = 1'b0;
    nclk(1);
    t_reset();
    t_filter();
    t_std();
    t_fast();
    t_clamp();
    t_stretch();
    t_pull();
    t_disable();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule